// File: doc/BRIEF.md
# Power Partition Wake-Up Sequencer

This block brings one power partition out of the gated state. A one-cycle request
pulse starts a fixed sequence. The block holds the partition in reset and turns its
clock off. It then asks for power and waits for the power switch to acknowledge. Next
it enables the clock and waits for the clock acknowledge. After a timed settle interval
it releases the isolation clamps and waits for the clamp acknowledge. After a second
settle interval of the same length it lets the partition out of reset. The block
reports success with a one-cycle `done_o` pulse. At that point power, clock and clamp
release are all left on.

Each acknowledge wait is bounded by a timeout. When a step times out, the block first
withdraws that step's request. It then undoes the steps already completed, in reverse
order and one per cycle, and finishes with a one-cycle `err_o` pulse. The partition
reset stays asserted after any failure. The settle interval is `CLK_MHZ * SETTLE_US`
clock cycles, which is a fixed time in microseconds at the block's clock rate. A request
that arrives while `busy_o` is high is dropped.

Top module: `pwrseq_ctrl`

## Requirements
- R1: After synchronous reset, `part_rst_o` is 1 and `pwr_en_o`, `clk_en_o`, `clamp_rel_o`, `busy_o`, `done_o` and `err_o` are all 0.
- R2: When `req_i` is sampled high while idle, on the next edge `busy_o` rises, `part_rst_o` is 1 and `clk_en_o` and `clamp_rel_o` are 0. `pwr_en_o` is 1 one edge later.
- R3: `clk_en_o` rises on the edge at which `pwr_ack_i` is first sampled high while the block waits for power.
- R4: `clamp_rel_o` rises exactly DELAY_CYC = CLK_MHZ*SETTLE_US edges after the edge at which `clk_ack_i` is sampled high.
- R5: Exactly DELAY_CYC edges after `clamp_ack_i` is sampled high, `part_rst_o` falls and `done_o` rises together, `busy_o` falls, and power, clock and clamp release stay at 1.
- R6: The power wait times out when `pwr_ack_i` has not been sampled high on any of the ACK_TIMEOUT edges after `pwr_en_o` rose. On the final edge of that window a high acknowledge still counts. On timeout `pwr_en_o` falls and `err_o` pulses on the same edge.
- R7: On a clock timeout (ACK_TIMEOUT edges after `clk_en_o` rose), `clk_en_o` falls. On the next edge `pwr_en_o` falls and `err_o` pulses.
- R8: On a clamp timeout, `clamp_rel_o`, then `clk_en_o`, then `pwr_en_o` fall on three consecutive edges. `err_o` pulses with the last of these, and `part_rst_o` stays 1.
- R9: `req_i` sampled while `busy_o` is 1 has no effect: the running sequence keeps its timing and output values.
- R10: `done_o` and `err_o` are single-cycle pulses that are never high together. `busy_o` is 0 in the cycle either one is high.
- R11: A request made while the partition is already up restarts the sequence from reset asserted, clock off and clamps engaged. It does not wait for acknowledges that are already high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Start pulse for the wake-up sequence |
| pwr_ack_i | input | 1 | Power switch reports the rail is up |
| clk_ack_i | input | 1 | Clock controller reports the clock is running |
| clamp_ack_i | input | 1 | Isolation logic reports the clamps are open |
| part_rst_o | output | 1 | Partition reset, 1 = held in reset |
| pwr_en_o | output | 1 | Power switch enable request |
| clk_en_o | output | 1 | Partition clock enable |
| clamp_rel_o | output | 1 | Isolation clamp release, 1 = released |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle success pulse |
| err_o | output | 1 | One-cycle failure pulse after unwinding |

## Verification
The bench builds the block with CLK_MHZ = 1, SETTLE_US = 10 and ACK_TIMEOUT = 6. This gives a ten-cycle settle interval and a six-cycle acknowledge timeout. With these values, both full settle waits and all three timeout-and-unwind paths fit in a few dozen cycles each, so every output change can be checked against an exact expected cycle. The small timeout also makes the last-edge acknowledge corner of the power wait easy to reach. The restart-from-up case with acknowledges already high is reachable in the same short run.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RESET,
        ST_PWR_WAIT,
        ST_CLK_WAIT,
        ST_SETTLE_A,
        ST_CLAMP_WAIT,
        ST_SETTLE_B,
        ST_UNDO_CLK,
        ST_UNDO_PWR
    } seq_state_e;

    typedef struct packed {
        logic part_rst;
        logic pwr_en;
        logic clk_en;
        logic clamp_rel;
    } part_ctl_t;

    localparam part_ctl_t CTL_GATED = '{part_rst: 1'b1, pwr_en: 1'b0,
                                        clk_en: 1'b0, clamp_rel: 1'b0};

    // Bits needed to hold n-1 (at least one bit).
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/pwrseq_timer.sv
module pwrseq_timer
    import pwrseq_pkg::*;
#(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    output logic expired_o
);
    localparam int W = cnt_width(LEN);
    localparam logic [W-1:0] START = W'(LEN - 1);

    logic [W-1:0] cnt_q;
    logic         run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load_i) begin
            cnt_q <= START;
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - W'(1);
        end
    end

    // Expired in the LEN-th cycle after the loading edge.
    assign expired_o = run_q && (cnt_q == '0);

    // R4: a load always restarts the full interval
    a_r4_load_restarts: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (run_q && cnt_q == START));

    // R6: an interval expires once unless reloaded
    a_r6_expire_once: assert property (@(posedge clk) disable iff (rst)
        (expired_o && !load_i) |=> !expired_o);

endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
    import pwrseq_pkg::*;
#(
    parameter int CLK_MHZ     = 200,
    parameter int SETTLE_US   = 10,
    parameter int ACK_TIMEOUT = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    input  logic pwr_ack_i,
    input  logic clk_ack_i,
    input  logic clamp_ack_i,
    output logic part_rst_o,
    output logic pwr_en_o,
    output logic clk_en_o,
    output logic clamp_rel_o,
    output logic busy_o,
    output logic done_o,
    output logic err_o
);
    localparam int DELAY_CYC = CLK_MHZ * SETTLE_US;

    seq_state_e state_q, state_d;
    part_ctl_t  ctl_q, ctl_d;
    logic       done_q, done_d, err_q, err_d;
    logic       settle_go, settle_exp;
    logic       guard_go, guard_exp;

    // Settle interval between clock-on and clamp release, and between
    // clamp release and reset release.
    pwrseq_timer #(.LEN(DELAY_CYC)) u_settle (
        .clk       (clk),
        .rst       (rst),
        .load_i    (settle_go),
        .expired_o (settle_exp)
    );

    // Bound on each acknowledge wait.
    pwrseq_timer #(.LEN(ACK_TIMEOUT)) u_guard (
        .clk       (clk),
        .rst       (rst),
        .load_i    (guard_go),
        .expired_o (guard_exp)
    );

    always_comb begin
        state_d   = state_q;
        ctl_d     = ctl_q;
        done_d    = 1'b0;
        err_d     = 1'b0;
        settle_go = 1'b0;
        guard_go  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req_i) begin
                    ctl_d.part_rst  = 1'b1;
                    ctl_d.clk_en    = 1'b0;
                    ctl_d.clamp_rel = 1'b0;
                    state_d         = ST_RESET;
                end
            end
            ST_RESET: begin
                ctl_d.pwr_en = 1'b1;
                guard_go     = 1'b1;
                state_d      = ST_PWR_WAIT;
            end
            ST_PWR_WAIT: begin
                if (pwr_ack_i) begin
                    ctl_d.clk_en = 1'b1;
                    guard_go     = 1'b1;
                    state_d      = ST_CLK_WAIT;
                end else if (guard_exp) begin
                    ctl_d.pwr_en = 1'b0;
                    err_d        = 1'b1;
                    state_d      = ST_IDLE;
                end
            end
            ST_CLK_WAIT: begin
                if (clk_ack_i) begin
                    settle_go = 1'b1;
                    state_d   = ST_SETTLE_A;
                end else if (guard_exp) begin
                    ctl_d.clk_en = 1'b0;
                    state_d      = ST_UNDO_PWR;
                end
            end
            ST_SETTLE_A: begin
                if (settle_exp) begin
                    ctl_d.clamp_rel = 1'b1;
                    guard_go        = 1'b1;
                    state_d         = ST_CLAMP_WAIT;
                end
            end
            ST_CLAMP_WAIT: begin
                if (clamp_ack_i) begin
                    settle_go = 1'b1;
                    state_d   = ST_SETTLE_B;
                end else if (guard_exp) begin
                    ctl_d.clamp_rel = 1'b0;
                    state_d         = ST_UNDO_CLK;
                end
            end
            ST_SETTLE_B: begin
                if (settle_exp) begin
                    ctl_d.part_rst = 1'b0;
                    done_d         = 1'b1;
                    state_d        = ST_IDLE;
                end
            end
            ST_UNDO_CLK: begin
                ctl_d.clk_en = 1'b0;
                state_d      = ST_UNDO_PWR;
            end
            ST_UNDO_PWR: begin
                ctl_d.pwr_en = 1'b0;
                err_d        = 1'b1;
                state_d      = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ctl_q   <= CTL_GATED;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ctl_q   <= ctl_d;
            done_q  <= done_d;
            err_q   <= err_d;
        end
    end

    assign part_rst_o  = ctl_q.part_rst;
    assign pwr_en_o    = ctl_q.pwr_en;
    assign clk_en_o    = ctl_q.clk_en;
    assign clamp_rel_o = ctl_q.clamp_rel;
    assign busy_o      = (state_q != ST_IDLE);
    assign done_o      = done_q;
    assign err_o       = err_q;

    // R10: outcome pulses are exclusive and last one cycle
    a_r10_outcome_excl: assert property (@(posedge clk) disable iff (rst)
        !(done_o && err_o));
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    a_r10_err_pulse: assert property (@(posedge clk) disable iff (rst)
        err_o |=> !err_o);

    // R2 / R11: a sequence starts with reset held, clock off, clamps engaged
    a_r2_start_state: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> (part_rst_o && !clk_en_o && !clamp_rel_o));

    // R3: the clock is enabled only after a power acknowledge
    a_r3_clk_after_pwr: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_en_o) |-> (pwr_en_o && $past(pwr_ack_i)));

    // R4: clamps are released only with power and clock on
    a_r4_clamp_needs_clk: assert property (@(posedge clk) disable iff (rst)
        clamp_rel_o |-> (clk_en_o && pwr_en_o));

    // R5: success leaves the partition fully up
    a_r5_done_up: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!part_rst_o && pwr_en_o && clk_en_o && clamp_rel_o));

    // R8: power is dropped last, with the error pulse, reset still held
    a_r8_unwind_last: assert property (@(posedge clk) disable iff (rst)
        $fell(pwr_en_o) |-> (!clk_en_o && !clamp_rel_o && err_o && part_rst_o));

    // R9: once busy, the block stays busy until it reports an outcome
    a_r9_busy_hold: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> (busy_o || done_o || err_o));

endmodule

// File: tb/pwrseq_ctrl_bench.sv
module pwrseq_ctrl_bench;
    localparam int CLK_MHZ = 1;
    localparam int SETTLE_US = 10;
    localparam int T = 6;
    localparam int D = CLK_MHZ * SETTLE_US;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0, pwr_ack = 1'b0, clk_ack = 1'b0, clamp_ack = 1'b0;
    logic part_rst_o, pwr_en_o, clk_en_o, clamp_rel_o, busy_o, done_o, err_o;

    pwrseq_ctrl #(.CLK_MHZ(CLK_MHZ), .SETTLE_US(SETTLE_US), .ACK_TIMEOUT(T)) u_pwrseq_ctrl (
        .clk(clk), .rst(rst), .req_i(req),
        .pwr_ack_i(pwr_ack), .clk_ack_i(clk_ack), .clamp_ack_i(clamp_ack),
        .part_rst_o(part_rst_o), .pwr_en_o(pwr_en_o), .clk_en_o(clk_en_o),
        .clamp_rel_o(clamp_rel_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit mon_on = 0;

    typedef struct {
        int         cyc;
        logic [6:0] vec;
        string      tag;
    } exp_t;
    exp_t sbq[$];

    // {busy, done, err, part_rst, pwr_en, clk_en, clamp_rel}
    function automatic logic [6:0] outv();
        return {busy_o, done_o, err_o, part_rst_o, pwr_en_o, clk_en_o, clamp_rel_o};
    endfunction

    task automatic push(input int c, input logic [6:0] v, input string tag);
        exp_t e;
        e.cyc = c;
        e.vec = v;
        e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: every change of the output vector must match the next expected item.
    logic [6:0] prev;
    always @(negedge clk) begin
        if (mon_on) begin
            logic [6:0] cur;
            cur = outv();
            if (cur !== prev) begin
                checks++;
                if (sbq.size() == 0) begin
                    errors++;
                    $display("FAIL unexpected change (R9): got %b at cycle %0d, expected no change", cur, cyc);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    if (e.vec !== cur || e.cyc != cyc) begin
                        errors++;
                        $display("FAIL %s: got %b at cycle %0d, expected %b at cycle %0d",
                                 e.tag, cur, cyc, e.vec, e.cyc);
                    end
                end
                prev = cur;
            end
        end
    end

    int c, p, q, r;

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        checks++;
        if (outv() !== 7'b0001000) begin
            errors++;
            $display("FAIL R1: got %b, expected %b", outv(), 7'b0001000);
        end
        prev = outv();
        mon_on = 1'b1;

        // Full success with staggered acknowledges, plus a request while busy.
        tick(1);
        req = 1'b1; c = cyc;
        push(c + 1, 7'b1001000, "R2");
        push(c + 2, 7'b1001100, "R2");
        tick(1); req = 1'b0;
        tick(3);
        pwr_ack = 1'b1; p = cyc;
        push(p + 1, 7'b1001110, "R3");
        tick(2);
        clk_ack = 1'b1; q = cyc;
        push(q + 1 + D, 7'b1001111, "R4");
        tick(3); req = 1'b1;
        tick(1); req = 1'b0;
        checks++;
        if (busy_o !== 1'b1 || clamp_rel_o !== 1'b0) begin
            errors++;
            $display("FAIL R9: busy/clamp got %b%b, expected 10", busy_o, clamp_rel_o);
        end
        tick(D - 1);
        clamp_ack = 1'b1; r = cyc;
        push(r + 1 + D, 7'b0100111, "R5");
        push(r + 2 + D, 7'b0000111, "R10");
        tick(D + 4);

        // Restart while up, every acknowledge already high.
        req = 1'b1; c = cyc;
        push(c + 1,         7'b1001100, "R11");
        push(c + 3,         7'b1001110, "R11");
        push(c + 4 + D,     7'b1001111, "R4");
        push(c + 5 + 2 * D, 7'b0100111, "R5");
        push(c + 6 + 2 * D, 7'b0000111, "R10");
        tick(1); req = 1'b0;
        tick(2 * D + 8);
        pwr_ack = 1'b0; clk_ack = 1'b0; clamp_ack = 1'b0;
        tick(2);

        // Power timeout.
        req = 1'b1; c = cyc;
        push(c + 1,     7'b1001100, "R11");
        push(c + 2 + T, 7'b0011000, "R6");
        push(c + 3 + T, 7'b0001000, "R10");
        tick(1); req = 1'b0;
        tick(T + 6);

        // Clock timeout.
        req = 1'b1; c = cyc;
        push(c + 1, 7'b1001000, "R2");
        push(c + 2, 7'b1001100, "R2");
        tick(1); req = 1'b0;
        tick(1); pwr_ack = 1'b1; p = cyc;
        push(p + 1,     7'b1001110, "R3");
        push(p + 1 + T, 7'b1001100, "R7");
        push(p + 2 + T, 7'b0011000, "R7");
        push(p + 3 + T, 7'b0001000, "R10");
        tick(T + 6);
        pwr_ack = 1'b0;
        tick(1);

        // Clamp timeout with full reverse unwind.
        req = 1'b1; c = cyc;
        push(c + 1, 7'b1001000, "R2");
        push(c + 2, 7'b1001100, "R2");
        tick(1); req = 1'b0;
        tick(1); pwr_ack = 1'b1; p = cyc;
        push(p + 1, 7'b1001110, "R3");
        tick(1); clk_ack = 1'b1; q = cyc;
        push(q + 1 + D,     7'b1001111, "R4");
        push(q + 1 + D + T, 7'b1001110, "R8");
        push(q + 2 + D + T, 7'b1001100, "R8");
        push(q + 3 + D + T, 7'b0011000, "R8");
        push(q + 4 + D + T, 7'b0001000, "R10");
        tick(D + T + 8);
        pwr_ack = 1'b0; clk_ack = 1'b0;
        tick(1);

        // Power acknowledge on the last edge of the timeout window still counts.
        req = 1'b1; c = cyc;
        push(c + 1, 7'b1001000, "R2");
        push(c + 2, 7'b1001100, "R2");
        tick(1); req = 1'b0;
        tick(T);
        pwr_ack = 1'b1; p = cyc;
        push(p + 1,     7'b1001110, "R6");
        push(p + 1 + T, 7'b1001100, "R7");
        push(p + 2 + T, 7'b0011000, "R7");
        push(p + 3 + T, 7'b0001000, "R10");
        tick(T + 6);
        pwr_ack = 1'b0;
        tick(2);

        checks++;
        if (sbq.size() != 0) begin
            errors++;
            $display("FAIL R5: %0d expected changes never seen, expected 0", sbq.size());
        end
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog R5: run did not end, got cycle %0d, expected completion", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule